// File: doc/BRIEF.md
# Operand Hazard Resolver for a Five-Stage In-Order Pipeline

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). For each of the two source operands of the instruction in decode, it compares the source register index against the destinations of the instructions now in execute, memory and writeback. It then either passes the register-file value through, substitutes a newer result taken from a later stage, or raises a decode stall that holds the instruction where it is.

Each later stage reports four things: a write flag, a destination index, a flag telling whether its result is already computed, and the result itself. A result is forwarded only when that flag is set and bypassing is enabled for that stage by a build-time parameter. In every other case a match stalls decode. A second build-time parameter selects a register file with asynchronous (zero-latency) or synchronous (one-cycle) reads. In the synchronous case a read started in the previous cycle missed the write that retired at that edge. The block therefore keeps a one-entry copy of the last retired write and forwards from it.

Top module: `operand_hazard_unit`

## Requirements
- R1: A source creates a dependency only when its use flag is set, its index is nonzero, and it equals the destination of a later stage whose write flag is set.
- R2: Register 0 never causes a stall or a forward, whatever the later stages hold.
- R3: When several stages match, only the youngest is considered, in the order execute, then memory, then writeback, then the retired-write copy. An older ready result never hides a stall owed to a younger one.
- R4: When the youngest matching stage has its result flag set and bypassing is enabled for it, the operand equals that stage's result and that source raises no stall.
- R5: When the youngest matching stage has its result flag clear, decode stalls.
- R6: When bypassing is disabled for the youngest matching stage, decode stalls even if its result flag is set.
- R7: With no match for a source, the operand equals the register-file read data for that source.
- R8: With synchronous register-file reads, a write presented by writeback in the previous clock cycle is forwarded as if it came from a ready stage, whatever the writeback bypass setting. This applies when no younger stage matches.
- R9: With asynchronous register-file reads, the previous cycle's writeback has no effect on the operands.
- R10: Synchronous reset clears the retired-write copy, so the first cycle after reset forwards nothing from it.
- R11: The two sources are resolved independently, and the decode stall is the OR of the two source stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs1_use | input | 1 | Decode instruction reads source 1 |
| dec_rs2_use | input | 1 | Decode instruction reads source 2 |
| dec_rs1 | input | REG_AW | Source 1 register index |
| dec_rs2 | input | REG_AW | Source 2 register index |
| rf_rs1_data | input | DATA_W | Register-file read data for source 1 |
| rf_rs2_data | input | DATA_W | Register-file read data for source 2 |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | REG_AW | Execute-stage destination index |
| ex_ready | input | 1 | Execute-stage result already computed |
| ex_result | input | DATA_W | Execute-stage result |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | REG_AW | Memory-stage destination index |
| mem_ready | input | 1 | Memory-stage result already computed |
| mem_result | input | DATA_W | Memory-stage result |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| wb_rd | input | REG_AW | Writeback-stage destination index |
| wb_ready | input | 1 | Writeback-stage result already computed |
| wb_result | input | DATA_W | Writeback-stage result |
| dec_stall | output | 1 | Hold the decode instruction this cycle |
| dec_op1 | output | DATA_W | Resolved source 1 operand |
| dec_op2 | output | DATA_W | Resolved source 2 operand |

## Verification
The bench drives two builds at once. One uses synchronous reads with memory bypass off; the other uses asynchronous reads with writeback bypass off. Random and directed streams aim at overlapping destinations, register 0, ready-but-blocked stages and the retired write. An inverted priority would forward a stale memory value over a fresh execute result, or would let an older ready stage cancel a stall the execute stage still owes. A missing retired copy in the synchronous build would hand decode a value one write too old. A leaking copy in the asynchronous build, or one not cleared at reset, would replace good register-file data with a phantom value.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Slot order, youngest first; the order is the forwarding priority.
  localparam int SLOT_EX   = 0;
  localparam int SLOT_MEM  = 1;
  localparam int SLOT_WB   = 2;
  localparam int SLOT_RET  = 3;
  localparam int PIPE_SLOTS = 3;
  localparam int NUM_SRC    = 2;

  function automatic int slot_count(input bit sync_rf);
    return sync_rf ? PIPE_SLOTS + 1 : PIPE_SLOTS;
  endfunction

  // Forward permission per slot: {retired, wb, mem, ex}; retired always allowed.
  function automatic logic [3:0] fwd_mask(input bit byp_ex, input bit byp_mem,
                                          input bit byp_wb);
    return {1'b1, byp_wb, byp_mem, byp_ex};
  endfunction
endpackage

// File: rtl/hzd_retire_slot.sv
module hzd_retire_slot #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_wr,
  input  logic [REG_AW-1:0] in_rd,
  input  logic [DATA_W-1:0] in_val,
  output logic              q_wr,
  output logic [REG_AW-1:0] q_rd,
  output logic [DATA_W-1:0] q_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_wr  <= 1'b0;
      q_rd  <= '0;
      q_val <= '0;
    end else begin
      q_wr  <= in_wr;
      q_rd  <= in_rd;
      q_val <= in_val;
    end
  end
endmodule

// File: rtl/hzd_src_resolve.sv
module hzd_src_resolve #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int NSLOT  = 3,
  parameter logic [NSLOT-1:0] FWD_OK = '1
) (
  input  logic              src_use,
  input  logic [REG_AW-1:0] src_idx,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              slot_wr  [NSLOT],
  input  logic [REG_AW-1:0] slot_rd  [NSLOT],
  input  logic              slot_rdy [NSLOT],
  input  logic [DATA_W-1:0] slot_val [NSLOT],
  output logic              hazard,
  output logic [DATA_W-1:0] operand
);
  logic             live;
  logic [NSLOT-1:0] hit;

  assign live = src_use && (src_idx != '0);

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign hit[i] = live && slot_wr[i] && (slot_rd[i] == src_idx);
  end

  // Walk oldest to youngest so that the youngest match is applied last.
  always_comb begin
    operand = rf_val;
    hazard  = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        operand = slot_val[i];
        hazard  = !(slot_rdy[i] && FWD_OK[i]);
      end
    end
  end
endmodule

// File: rtl/operand_hazard_unit.sv
module operand_hazard_unit #(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter bit BYP_EX  = 1'b1,
  parameter bit BYP_MEM = 1'b1,
  parameter bit BYP_WB  = 1'b1,
  parameter bit SYNC_RF = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_rs1_use,
  input  logic              dec_rs2_use,
  input  logic [REG_AW-1:0] dec_rs1,
  input  logic [REG_AW-1:0] dec_rs2,
  input  logic [DATA_W-1:0] rf_rs1_data,
  input  logic [DATA_W-1:0] rf_rs2_data,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_ready,
  input  logic [DATA_W-1:0] ex_result,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_result,
  input  logic              wb_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_ready,
  input  logic [DATA_W-1:0] wb_result,
  output logic              dec_stall,
  output logic [DATA_W-1:0] dec_op1,
  output logic [DATA_W-1:0] dec_op2
);
  import hzd_pkg::*;

  localparam int NSLOT = slot_count(SYNC_RF);
  localparam logic [NSLOT-1:0] FWD_OK = NSLOT'(fwd_mask(BYP_EX, BYP_MEM, BYP_WB));

  logic              s_wr  [NSLOT];
  logic [REG_AW-1:0] s_rd  [NSLOT];
  logic              s_rdy [NSLOT];
  logic [DATA_W-1:0] s_val [NSLOT];

  assign s_wr[SLOT_EX]   = ex_wr;
  assign s_rd[SLOT_EX]   = ex_rd;
  assign s_rdy[SLOT_EX]  = ex_ready;
  assign s_val[SLOT_EX]  = ex_result;
  assign s_wr[SLOT_MEM]  = mem_wr;
  assign s_rd[SLOT_MEM]  = mem_rd;
  assign s_rdy[SLOT_MEM] = mem_ready;
  assign s_val[SLOT_MEM] = mem_result;
  assign s_wr[SLOT_WB]   = wb_wr;
  assign s_rd[SLOT_WB]   = wb_rd;
  assign s_rdy[SLOT_WB]  = wb_ready;
  assign s_val[SLOT_WB]  = wb_result;

  if (SYNC_RF) begin : g_sync
    // The synchronous read missed the write that retired at the last edge.
    logic              ret_wr;
    logic [REG_AW-1:0] ret_rd;
    logic [DATA_W-1:0] ret_val;

    hzd_retire_slot #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_ret (
      .clk   (clk),
      .rst   (rst),
      .in_wr (wb_wr),
      .in_rd (wb_rd),
      .in_val(wb_result),
      .q_wr  (ret_wr),
      .q_rd  (ret_rd),
      .q_val (ret_val)
    );

    assign s_wr[NSLOT-1]  = ret_wr;
    assign s_rd[NSLOT-1]  = ret_rd;
    assign s_rdy[NSLOT-1] = 1'b1;
    assign s_val[NSLOT-1] = ret_val;
  end

  logic              src_use [NUM_SRC];
  logic [REG_AW-1:0] src_idx [NUM_SRC];
  logic [DATA_W-1:0] src_rf  [NUM_SRC];
  logic [DATA_W-1:0] src_op  [NUM_SRC];
  logic [NUM_SRC-1:0] src_haz;

  assign src_use[0] = dec_rs1_use;
  assign src_use[1] = dec_rs2_use;
  assign src_idx[0] = dec_rs1;
  assign src_idx[1] = dec_rs2;
  assign src_rf[0]  = rf_rs1_data;
  assign src_rf[1]  = rf_rs2_data;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hzd_src_resolve #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .NSLOT(NSLOT), .FWD_OK(FWD_OK)
    ) u_res (
      .src_use (src_use[s]),
      .src_idx (src_idx[s]),
      .rf_val  (src_rf[s]),
      .slot_wr (s_wr),
      .slot_rd (s_rd),
      .slot_rdy(s_rdy),
      .slot_val(s_val),
      .hazard  (src_haz[s]),
      .operand (src_op[s])
    );
  end

  assign dec_stall = |src_haz;
  assign dec_op1   = src_op[0];
  assign dec_op2   = src_op[1];
endmodule

// File: rtl/operand_hazard_unit_chk.sv
module operand_hazard_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter bit BYP_EX  = 1'b1,
  parameter bit BYP_MEM = 1'b1,
  parameter bit BYP_WB  = 1'b1,
  parameter bit SYNC_RF = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              dec_rs1_use,
  input logic              dec_rs2_use,
  input logic [REG_AW-1:0] dec_rs1,
  input logic [REG_AW-1:0] dec_rs2,
  input logic [DATA_W-1:0] rf_rs1_data,
  input logic [DATA_W-1:0] rf_rs2_data,
  input logic              ex_wr,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_ready,
  input logic [DATA_W-1:0] ex_result,
  input logic              mem_wr,
  input logic [REG_AW-1:0] mem_rd,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_result,
  input logic              wb_wr,
  input logic [REG_AW-1:0] wb_rd,
  input logic              wb_ready,
  input logic [DATA_W-1:0] wb_result,
  input logic              dec_stall,
  input logic [DATA_W-1:0] dec_op1,
  input logic [DATA_W-1:0] dec_op2
);
  // Independent copy of the last writeback, for the retired-write checks.
  logic              c_wr;
  logic [REG_AW-1:0] c_rd;
  logic [DATA_W-1:0] c_val;
  always_ff @(posedge clk) begin
    if (rst) begin
      c_wr <= 1'b0; c_rd <= '0; c_val <= '0;
    end else begin
      c_wr <= wb_wr; c_rd <= wb_rd; c_val <= wb_result;
    end
  end

  logic live1, live2, m1_ex, m1_mem, m1_wb, m1_ret, m2_ex, m2_mem, m2_wb, m2_ret;
  assign live1  = dec_rs1_use && (dec_rs1 != '0);
  assign live2  = dec_rs2_use && (dec_rs2 != '0);
  assign m1_ex  = live1 && ex_wr  && (ex_rd  == dec_rs1);
  assign m1_mem = live1 && mem_wr && (mem_rd == dec_rs1);
  assign m1_wb  = live1 && wb_wr  && (wb_rd  == dec_rs1);
  assign m1_ret = live1 && SYNC_RF && c_wr && (c_rd == dec_rs1);
  assign m2_ex  = live2 && ex_wr  && (ex_rd  == dec_rs2);
  assign m2_mem = live2 && mem_wr && (mem_rd == dec_rs2);
  assign m2_wb  = live2 && wb_wr  && (wb_rd  == dec_rs2);
  assign m2_ret = live2 && SYNC_RF && c_wr && (c_rd == dec_rs2);

  // R2
  zero_src_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!live1 && !live2) |-> !dec_stall);

  // R4
  ex_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (BYP_EX && m1_ex && ex_ready) |-> (dec_op1 == ex_result));

  // R4
  mem_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (BYP_MEM && m1_mem && !m1_ex && mem_ready) |-> (dec_op1 == mem_result));

  // R4
  wb_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (BYP_WB && m1_wb && !m1_ex && !m1_mem && wb_ready) |-> (dec_op1 == wb_result));

  // R5
  ex_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ((m1_ex || m2_ex) && !ex_ready) |-> dec_stall);

  // R6
  mem_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!BYP_MEM && m1_mem && !m1_ex) |-> dec_stall);

  // R3
  youngest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (BYP_EX && m1_ex && ex_ready && m1_mem && !mem_ready && !live2) |-> !dec_stall);

  // R7
  pass1_chk: assert property (@(posedge clk) disable iff (rst)
    (!m1_ex && !m1_mem && !m1_wb && !m1_ret) |-> (dec_op1 == rf_rs1_data));

  // R7
  pass2_chk: assert property (@(posedge clk) disable iff (rst)
    (!m2_ex && !m2_mem && !m2_wb && !m2_ret) |-> (dec_op2 == rf_rs2_data));

  // R8
  ret_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (m1_ret && !m1_ex && !m1_mem && !m1_wb) |-> (dec_op1 == c_val));
endmodule

bind operand_hazard_unit operand_hazard_unit_chk #(
  .DATA_W(DATA_W), .REG_AW(REG_AW), .BYP_EX(BYP_EX), .BYP_MEM(BYP_MEM),
  .BYP_WB(BYP_WB), .SYNC_RF(SYNC_RF)
) u_chk (.*);

// File: tb/operand_hazard_unit_test.sv
module operand_hazard_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       rs1_use, rs2_use;
  logic [2:0] rs1, rs2;
  logic [7:0] rf1, rf2;
  logic       ex_wr, ex_rdy, mem_wr, mem_rdy, wb_wr, wb_rdy;
  logic [2:0] ex_rd, mem_rd, wb_rd;
  logic [7:0] ex_res, mem_res, wb_res;
  logic       st_a, st_b;
  logic [7:0] o1_a, o2_a, o1_b, o2_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Build A: synchronous reads, memory bypass off.
  operand_hazard_unit #(.DATA_W(8), .REG_AW(3), .BYP_EX(1), .BYP_MEM(0),
                        .BYP_WB(1), .SYNC_RF(1)) uut (
    .clk(clk), .rst(rst), .dec_rs1_use(rs1_use), .dec_rs2_use(rs2_use),
    .dec_rs1(rs1), .dec_rs2(rs2), .rf_rs1_data(rf1), .rf_rs2_data(rf2),
    .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_ready(ex_rdy), .ex_result(ex_res),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_ready(mem_rdy), .mem_result(mem_res),
    .wb_wr(wb_wr), .wb_rd(wb_rd), .wb_ready(wb_rdy), .wb_result(wb_res),
    .dec_stall(st_a), .dec_op1(o1_a), .dec_op2(o2_a));

  // Build B: asynchronous reads, writeback bypass off.
  operand_hazard_unit #(.DATA_W(8), .REG_AW(3), .BYP_EX(1), .BYP_MEM(1),
                        .BYP_WB(0), .SYNC_RF(0)) uut_async (
    .clk(clk), .rst(rst), .dec_rs1_use(rs1_use), .dec_rs2_use(rs2_use),
    .dec_rs1(rs1), .dec_rs2(rs2), .rf_rs1_data(rf1), .rf_rs2_data(rf2),
    .ex_wr(ex_wr), .ex_rd(ex_rd), .ex_ready(ex_rdy), .ex_result(ex_res),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_ready(mem_rdy), .mem_result(mem_res),
    .wb_wr(wb_wr), .wb_rd(wb_rd), .wb_ready(wb_rdy), .wb_result(wb_res),
    .dec_stall(st_b), .dec_op1(o1_b), .dec_op2(o2_b));

  // Bench copy of the previous cycle's writeback (R8, R10).
  logic       p_wr;
  logic [2:0] p_rd;
  logic [7:0] p_val;
  always @(posedge clk) begin
    if (rst) begin p_wr <= 1'b0; p_rd <= '0; p_val <= '0; end
    else begin p_wr <= wb_wr; p_rd <= wb_rd; p_val <= wb_result_q(); end
  end
  function automatic logic [7:0] wb_result_q(); return wb_res; endfunction

  // Spec model for one source (R1..R9).
  task automatic model(input logic use_f, input logic [2:0] idx, input logic [7:0] rf,
                       input bit bex, input bit bmem, input bit bwb, input bit sync,
                       output logic [7:0] op, output bit haz, output string tag);
    op = rf; haz = 0; tag = "R7";
    if (!use_f || idx == 3'd0) begin
      tag = "R2";
    end else if (ex_wr && ex_rd == idx) begin
      op = ex_res; haz = !(bex && ex_rdy);
      tag = !ex_rdy ? "R5" : (!bex ? "R6" : "R4");
    end else if (mem_wr && mem_rd == idx) begin
      op = mem_res; haz = !(bmem && mem_rdy);
      tag = !mem_rdy ? "R5" : (!bmem ? "R6" : "R3");
    end else if (wb_wr && wb_rd == idx) begin
      op = wb_res; haz = !(bwb && wb_rdy);
      tag = !wb_rdy ? "R5" : (!bwb ? "R6" : "R3");
    end else if (p_wr && p_rd == idx) begin
      if (sync) begin op = p_val; tag = "R8"; end
      else tag = "R9";
    end
  endtask

  task automatic check_cfg(input string nm, input bit bex, input bit bmem, input bit bwb,
                           input bit sync, input logic st, input logic [7:0] a1,
                           input logic [7:0] a2);
    logic [7:0] e1, e2; bit h1, h2; string t1, t2;
    model(rs1_use, rs1, rf1, bex, bmem, bwb, sync, e1, h1, t1);
    model(rs2_use, rs2, rf2, bex, bmem, bwb, sync, e2, h2, t2);
    // R1 / R11: stall is the OR of the per-source dependencies
    n_cmp++;
    if (st !== (h1 | h2)) begin
      n_bad++;
      $display("FAIL %s R11 (%s,%s) stall=%0b expected %0b", nm, t1, t2, st, h1 | h2);
    end
    if (!h1) begin
      n_cmp++;
      if (a1 !== e1) begin
        n_bad++;
        $display("FAIL %s %s op1=%h expected %h", nm, t1, a1, e1);
      end
    end
    if (!h2) begin
      n_cmp++;
      if (a2 !== e2) begin
        n_bad++;
        $display("FAIL %s %s op2=%h expected %h", nm, t2, a2, e2);
      end
    end
  endtask

  task automatic check_all();
    check_cfg("sync", 1, 0, 1, 1, st_a, o1_a, o2_a);
    check_cfg("async", 1, 1, 0, 0, st_b, o1_b, o2_b);
  endtask

  task automatic clear_all();
    rs1_use = 0; rs2_use = 0; rs1 = 0; rs2 = 0; rf1 = 8'hA1; rf2 = 8'hB2;
    ex_wr = 0; ex_rd = 0; ex_rdy = 0; ex_res = 8'h01;
    mem_wr = 0; mem_rd = 0; mem_rdy = 0; mem_res = 8'h02;
    wb_wr = 0; wb_rd = 0; wb_rdy = 0; wb_res = 8'h03;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    clear_all();
    // R10: a writeback held during reset must not survive into the first cycle.
    wb_wr = 1; wb_rd = 3; wb_rdy = 1; wb_res = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0; wb_wr = 0; rs1_use = 1; rs1 = 3;
    #1;
    n_cmp++;
    if (o1_a !== rf1 || st_a !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 op1=%h stall=%0b expected %h stall=0", o1_a, st_a, rf1);
    end
    check_all();

    // R4 (sync) / R6 (async, wb bypass off)
    @(negedge clk); wb_wr = 1; wb_rd = 3; wb_rdy = 1; wb_res = 8'h11; #1; check_all();
    // R8 (sync retired copy) / R9 (async ignores it)
    @(negedge clk); wb_wr = 0; #1; check_all();
    // R3: execute beats memory
    @(negedge clk); clear_all(); rs1_use = 1; rs1 = 3;
    ex_wr = 1; ex_rd = 3; ex_rdy = 1; ex_res = 8'h44;
    mem_wr = 1; mem_rd = 3; mem_rdy = 1; mem_res = 8'h55; #1; check_all();
    // R3: ready older stage cannot hide execute's pending result
    @(negedge clk); ex_rdy = 0; #1; check_all();
    // R6: memory ready but bypass disabled in the sync build
    @(negedge clk); ex_wr = 0; ex_rdy = 1; #1; check_all();
    // R2: register 0 matches a pending destination 0
    @(negedge clk); clear_all(); rs1_use = 1; rs1 = 0; rs2_use = 1; rs2 = 0;
    ex_wr = 1; ex_rd = 0; ex_rdy = 0; #1; check_all();
    // R11: only source 2 depends
    @(negedge clk); clear_all(); rs1_use = 1; rs1 = 2; rs2_use = 1; rs2 = 5;
    ex_wr = 1; ex_rd = 5; ex_rdy = 0; #1; check_all();
    // R1: unused source matching a pending write
    @(negedge clk); rs2_use = 0; #1; check_all();

    // Random streams over the small build (R1..R9, R11)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rs1_use = 1'($urandom); rs2_use = 1'($urandom);
      rs1 = 3'($urandom); rs2 = 3'($urandom);
      rf1 = 8'($urandom); rf2 = 8'($urandom);
      ex_wr = 1'($urandom); ex_rdy = 1'($urandom); ex_res = 8'($urandom);
      ex_rd = ($urandom % 2) ? rs1 : 3'($urandom);
      mem_wr = 1'($urandom); mem_rdy = 1'($urandom); mem_res = 8'($urandom);
      mem_rd = ($urandom % 2) ? rs2 : 3'($urandom);
      wb_wr = 1'($urandom); wb_rdy = 1'($urandom); wb_res = 8'($urandom);
      wb_rd = ($urandom % 2) ? rs1 : 3'($urandom);
      #1; check_all();
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements) run unfinished expected completion");
      summary();
      $finish;
    end
  end
endmodule